// File: doc/BRIEF.md
# Dual-Strobe Decade Up/Down Counter

A single-digit BCD counter that is stepped by two separate strobes instead of a direction select. A rising edge on the up strobe advances the digit and a rising edge on the down strobe retreats it. Either edge is accepted only while the opposite strobe rests high. Both strobes are asynchronous to the block. They pass through two-flop synchronizers clocked by the system clock, and the edges are found after the synchronizers. A digit can be forced with an active-low parallel load, or zeroed with an active-high clear. The clear wins over the load, and both win over the strobes.

Two active-low terminal-count outputs let digits be chained. The carry output drops while the digit is 9 and the up strobe is low. The borrow output drops while the digit is 0 and the down strobe is low. A following digit takes carry on its up strobe and borrow on its down strobe. Each wrap of the lower digit then makes exactly one rising edge on the next digit's input. Loaded values of 10 to 15 fall back into the decade through a fixed recovery path.

Top module: `bcd_updown_counter`

## Requirements
- R1: While rst_ni is low, count_o is 0 and carry_no and borrow_no are 1. After release, with both strobes high, nothing changes.
- R2: With clear_i high, count_o is 0 after the next system clock edge. This holds regardless of load_ni, preset_i and both strobes.
- R3: With clear_i low and load_ni low, count_o equals preset_i after each system clock edge. Strobe edges are ignored for as long as the load is held.
- R4: A rising edge on up_i while dn_i is high steps the digit 0 to 1 and so on up to 8 to 9, and 9 wraps to 0. count_o changes on the third system clock edge after up_i rises.
- R5: A rising edge on dn_i while up_i is high steps 0 to 9, and every other value (1 to 15) to that value minus one.
- R6: From an out-of-range digit, one up step maps 10 to 11, 11 to 6, 12 to 13, 13 to 4, 14 to 15 and 15 to 2.
- R7: A rising edge on one strobe while the other strobe is low leaves count_o unchanged. Falling edges never change count_o.
- R8: If both strobes rise in the same system clock cycle, count_o is unchanged.
- R9: carry_no is 0 exactly when count_o bits 0 and 3 are both set and up_i has been low for at least two system clocks. Otherwise it is 1.
- R10: borrow_no is 0 exactly when count_o is 0 and dn_i has been low for at least two system clocks. Otherwise it is 1.
- R11: Two digits can be chained, the low digit's carry_no driving the next digit's up_i and borrow_no driving its dn_i. The pair then counts 00 to 99 and back as a two-digit decimal number, with one step of the upper digit per wrap of the lower digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples both strobes |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Active-high clear of the digit |
| load_ni | input | 1 | Active-low parallel load of preset_i |
| preset_i | input | 4 | Value copied in by the load |
| up_i | input | 1 | Count-up strobe, rising edge steps up |
| dn_i | input | 1 | Count-down strobe, rising edge steps down |
| count_o | output | 4 | Current digit |
| carry_no | output | 1 | Active-low terminal count for up counting |
| borrow_no | output | 1 | Active-low terminal count for down counting |

## Verification
The assertions assume that each strobe holds a level for at least two system clocks, so that every transition reaches the synchronizer output. They also assume that clear and load are held steady across a clock edge. The stimulus holds every strobe level for four to six clocks. It changes clear, load and preset only on the falling clock edge, and it never pulses a strobe while a load or clear is in progress, except in the case that checks that such a pulse is ignored.

// File: rtl/bcd_ctr_pkg.sv
package bcd_ctr_pkg;
  localparam int DIGIT_W = 4;
  localparam int SYNC_STAGES = 2;
  typedef logic [DIGIT_W-1:0] digit_t;

  function automatic digit_t next_up(digit_t s);
    case (s)
      4'd9:    return 4'd0;
      4'd10:   return 4'd11;
      4'd11:   return 4'd6;
      4'd12:   return 4'd13;
      4'd13:   return 4'd4;
      4'd14:   return 4'd15;
      4'd15:   return 4'd2;
      default: return s + 4'd1;
    endcase
  endfunction

  function automatic digit_t next_dn(digit_t s);
    return (s == 4'd0) ? 4'd9 : s - 4'd1;
  endfunction
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  // idle-high reset: a strobe resting high after reset is not an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      prev_q <= 1'b1;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], strobe_i};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign level_o = sh_q[STAGES-1];
  assign rise_o  = sh_q[STAGES-1] & ~prev_q;

  a_r4_single_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/decade_state.sv
module decade_state
  import bcd_ctr_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   clear_i,
  input  logic   load_ni,
  input  digit_t preset_i,
  input  logic   inc_i,
  input  logic   dec_i,
  output digit_t state_o
);
  digit_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (clear_i)       state_d = '0;
    else if (!load_ni) state_d = preset_i;
    else if (inc_i)    state_d = next_up(state_q);
    else if (dec_i)    state_d = next_dn(state_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= '0;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  a_r2_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> state_q == 4'd0);
  a_r3_load_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !load_ni) |=> state_q == $past(preset_i));
  a_r4_up_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clear_i && load_ni && state_q < 4'd9) |=> state_q == $past(state_q) + 4'd1);
  a_r5_dn_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !clear_i && load_ni && state_q != 4'd0) |=> state_q == $past(state_q) - 4'd1);
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !dec_i && !clear_i && load_ni) |=> $stable(state_q));
endmodule

// File: rtl/term_count.sv
module term_count
  import bcd_ctr_pkg::*;
(
  input  digit_t state_i,
  input  logic   up_lvl_i,
  input  logic   dn_lvl_i,
  output logic   carry_no,
  output logic   borrow_no
);
  assign carry_no  = ~(state_i[0] & state_i[3] & ~up_lvl_i);
  assign borrow_no = ~((state_i == '0) & ~dn_lvl_i);
endmodule

// File: rtl/bcd_updown_counter.sv
module bcd_updown_counter
  import bcd_ctr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic       load_ni,
  input  logic [3:0] preset_i,
  input  logic       up_i,
  input  logic       dn_i,
  output logic [3:0] count_o,
  output logic       carry_no,
  output logic       borrow_no
);
  localparam int N_STRB = 2; // index 0 up, 1 down

  logic [N_STRB-1:0] strb, lvl, rise;
  logic              inc, dec;
  digit_t            state;

  assign strb = {dn_i, up_i};

  for (genvar g = 0; g < N_STRB; g++) begin : g_sync
    strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .strobe_i(strb[g]),
      .level_o (lvl[g]),
      .rise_o  (rise[g])
    );
  end

  // an edge counts only with the opposite strobe high; coincident edges cancel
  assign inc = rise[0] & lvl[1] & ~rise[1];
  assign dec = rise[1] & lvl[0] & ~rise[0];

  decade_state u_state (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .load_ni (load_ni),
    .preset_i(preset_i),
    .inc_i   (inc),
    .dec_i   (dec),
    .state_o (state)
  );

  term_count u_tc (
    .state_i  (state),
    .up_lvl_i (lvl[0]),
    .dn_lvl_i (lvl[1]),
    .carry_no (carry_no),
    .borrow_no(borrow_no)
  );

  assign count_o = state;

  a_r9_carry_blocks_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!carry_no && !clear_i && load_ni) |=> count_o != 4'd0);
  a_r10_borrow_blocks_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!borrow_no && !clear_i && load_ni) |=> count_o != 4'd9);
endmodule

// File: tb/bcd_updown_counter_bench.sv
module bcd_updown_counter_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       clear_i = 1'b0;
  logic       load_ni = 1'b1;
  logic [3:0] preset_i = 4'd0;
  logic       up_i = 1'b1;
  logic       dn_i = 1'b1;
  logic [3:0] count_o, hi_count;
  logic       carry_no, borrow_no, hi_carry_n, hi_borrow_n;

  int checks = 0;
  int errors = 0;
  int m = 0;

  always #5 clk = ~clk;

  bcd_updown_counter u_bcd_updown_counter (
    .clk_i(clk), .rst_ni(rst_ni), .clear_i(clear_i), .load_ni(load_ni),
    .preset_i(preset_i), .up_i(up_i), .dn_i(dn_i),
    .count_o(count_o), .carry_no(carry_no), .borrow_no(borrow_no));

  bcd_updown_counter u_hi (
    .clk_i(clk), .rst_ni(rst_ni), .clear_i(clear_i), .load_ni(1'b1),
    .preset_i(4'd0), .up_i(carry_no), .dn_i(borrow_no),
    .count_o(hi_count), .carry_no(hi_carry_n), .borrow_no(hi_borrow_n));

  function automatic int m_up(int s);
    case (s)
      9: return 0;   10: return 11; 11: return 6; 12: return 13;
      13: return 4;  14: return 15; 15: return 2;
      default: return s + 1;
    endcase
  endfunction

  function automatic int m_dn(int s);
    return (s == 0) ? 9 : s - 1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic up_pulse();
    up_i = 1'b0;
    wait_n(6);
    chk("R9 carry level", int'(carry_no), ((m % 2 == 1) && m >= 8) ? 0 : 1);
    up_i = 1'b1;
    wait_n(6);
    if (dn_i) m = m_up(m);
  endtask

  task automatic dn_pulse();
    dn_i = 1'b0;
    wait_n(6);
    chk("R10 borrow level", int'(borrow_no), (m == 0) ? 0 : 1);
    dn_i = 1'b1;
    wait_n(6);
    if (up_i) m = m_dn(m);
  endtask

  task automatic load_val(input int v);
    preset_i = 4'(v);
    load_ni = 1'b0;
    wait_n(1);
    chk("R3 load", int'(count_o), v);
    load_ni = 1'b1;
    wait_n(1);
    m = v;
  endtask

  task automatic do_clear();
    clear_i = 1'b1;
    wait_n(1);
    chk("R2 clear", int'(count_o), 0);
    clear_i = 1'b0;
    wait_n(1);
    m = 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    wait_n(3);
    chk("R1 reset count", int'(count_o), 0);
    chk("R1 reset carry", int'(carry_no), 1);
    chk("R1 reset borrow", int'(borrow_no), 1);
    rst_ni = 1'b1;
    wait_n(4);
    chk("R1 idle after release", int'(count_o), 0);

    // R4 R5 R6: every start state, both directions
    for (int s = 0; s < 16; s++) begin
      load_val(s);
      up_pulse();
      chk(s < 10 ? "R4 up step" : "R6 recovery up", int'(count_o), m);
      load_val(s);
      dn_pulse();
      chk("R5 down step", int'(count_o), m);
    end

    // R4 latency: third clock edge after the rise
    load_val(3);
    up_i = 1'b0;
    wait_n(4);
    up_i = 1'b1;
    wait_n(2);
    chk("R4 no change before third edge", int'(count_o), 3);
    wait_n(1);
    chk("R4 change on third edge", int'(count_o), 4);
    wait_n(4);
    m = 4;

    // full decade both ways
    do_clear();
    for (int i = 0; i < 10; i++) begin
      up_pulse();
      chk("R4 decade up", int'(count_o), m);
    end
    for (int i = 0; i < 10; i++) begin
      dn_pulse();
      chk("R5 decade down", int'(count_o), m);
    end

    // R7 gating
    load_val(5);
    dn_i = 1'b0;
    wait_n(4);
    up_pulse();
    chk("R7 up gated by low down strobe", int'(count_o), 5);
    dn_i = 1'b1;
    wait_n(6);
    chk("R7 down rise with up high counts", int'(count_o), 4);
    m = 4;
    up_i = 1'b0;
    wait_n(4);
    dn_pulse();
    chk("R7 down gated by low up strobe", int'(count_o), 4);
    up_i = 1'b1;
    wait_n(6);
    m = m_up(m);
    chk("R7 up rise with down high counts", int'(count_o), m);

    // R8 simultaneous rising edges
    up_i = 1'b0; dn_i = 1'b0;
    wait_n(6);
    up_i = 1'b1; dn_i = 1'b1;
    wait_n(6);
    chk("R8 coincident edges ignored", int'(count_o), m);

    // R3 load tracks preset and masks strobes
    preset_i = 4'd7;
    load_ni = 1'b0;
    wait_n(1);
    chk("R3 load copy", int'(count_o), 7);
    preset_i = 4'd2;
    wait_n(1);
    chk("R3 load tracks preset", int'(count_o), 2);
    up_i = 1'b0; wait_n(6); up_i = 1'b1; wait_n(6);
    chk("R3 strobe ignored under load", int'(count_o), 2);
    load_ni = 1'b1;
    wait_n(1);
    m = 2;

    // R2 clear beats load
    preset_i = 4'd8;
    load_ni = 1'b0;
    clear_i = 1'b1;
    wait_n(2);
    chk("R2 clear over load", int'(count_o), 0);
    clear_i = 1'b0;
    load_ni = 1'b1;
    wait_n(1);
    m = 0;

    // random mix
    for (int i = 0; i < 300; i++) begin
      case ($urandom % 8)
        0: load_val(int'($urandom % 16));
        1: do_clear();
        2, 3, 4: begin up_pulse(); chk("R4 R6 random up", int'(count_o), m); end
        default: begin dn_pulse(); chk("R5 random down", int'(count_o), m); end
      endcase
    end

    // R11 two-digit cascade
    do_clear();
    wait_n(4);
    chk("R11 cascade start", int'(hi_count) * 10 + int'(count_o), 0);
    for (int n = 1; n <= 99; n++) begin
      up_pulse();
      chk("R11 cascade up", int'(hi_count) * 10 + int'(count_o), n);
    end
    for (int n = 98; n >= 0; n--) begin
      dn_pulse();
      chk("R11 cascade down", int'(hi_count) * 10 + int'(count_o), n);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule